// File: doc/BRIEF.md
# Debounced Edge Counter with Wake

This block watches one slow external input and turns clean, alternating transitions into a wake request. The input is first passed through a two-stage synchronizer. Each time a periodic sample strobe is high, the synchronized level is compared with the polarity of the edge the block is waiting for. The first edge it waits for is a rising one.

A sample that matches the awaited polarity counts as "changed". Before an edge is accepted, a run of consecutive changed samples must exhaust a reloadable down-counter. Any sample that does not match restarts that counter at the configured reload value. Once an edge is accepted, the awaited polarity flips and a 16-bit edge counter advances.

When the advanced edge count equals the configured threshold, three things happen on the same sample:
- the edge count returns to zero;
- a 16-bit wake counter advances;
- a wake pulse one clock wide is produced.

With a reload of 3 and a threshold of 2, a single high-then-low pulse produces one wake. Each level of that pulse must last at least four sample periods.

Top module: `edge_wake_counter`

## Requirements
- R1: After reset, edge_count and wake_count are 0, wake_pulse is 0, the debounce counter behaves as if loaded with cfg_reload, and the awaited edge is rising (a sample at level 1 counts as changed, a sample at level 0 does not).
- R2: A sample whose synchronized level differs from the awaited polarity (1 = rising awaited, 0 = falling awaited) is unchanged: it reloads the debounce counter with cfg_reload and leaves both counters and the awaited polarity untouched.
- R3: A changed sample while the debounce counter is non-zero decrements that counter by one and changes no output.
- R4: A changed sample while the debounce counter is zero confirms an edge: the awaited polarity toggles, the debounce counter reloads and edge_count advances by one.
- R5: When the advanced edge count equals cfg_threshold, wake_count advances by one, edge_count becomes 0 and wake_pulse is high for exactly one clock, in the clock after the sampling edge.
- R6: An edge is confirmed after cfg_reload+1 consecutive changed samples and not after cfg_reload of them.
- R7: On clocks where sample_stb is low, no state changes, whatever raw_in does.
- R8: raw_in passes through a two-flop synchronizer. A strobe sees the raw level present two clocks before its sampling edge, and does not see a change made in the clock just before it.
- R9: edge_count and wake_count are 16 bits wide and wrap. With cfg_threshold = 0 the wake fires on the edge that wraps edge_count from 65535 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_stb | input | 1 | One-clock sample enable from the periodic timer |
| raw_in | input | 1 | Unsynchronized monitored input |
| cfg_reload | input | 8 | Debounce reload value |
| cfg_threshold | input | 16 | Number of confirmed edges per wake |
| wake_pulse | output | 1 | One-clock wake request |
| edge_count | output | 16 | Confirmed edges since the last wake |
| wake_count | output | 16 | Number of wakes issued |

## Verification
A wrong awaited polarity shows up on the next sample: edges are then counted on the opposite level, so edge_count advances one sample too early, or not at all. A debounce counter off by one moves the confirmation by one sample period. This is visible in edge_count right after the strobe that should, or should not, have confirmed. A wrong threshold comparison or a wrong counter reset shows at the next wake, either as an edge_count that does not return to zero or as a wake_count step that is missing or extra.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  // Polarity of the edge the block is waiting for.
  typedef enum logic {
    AWAIT_FALL = 1'b0,
    AWAIT_RISE = 1'b1
  } await_pol_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/ewc_rst_sync.sv
module ewc_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ewc_sync.sv
module ewc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/ewc_debounce.sv
module ewc_debounce
  import ewc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          level,
  input  logic [DW-1:0] reload,
  output logic          edge_ok,
  output logic          await_pol
);
  await_pol_e    pol_q, pol_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          primed_q, primed_d;
  logic [DW-1:0] cnt_eff;
  logic          changed;

  // Until the first strobe the counter is taken as holding the reload value.
  assign cnt_eff = primed_q ? cnt_q : reload;
  assign changed = (level == pol_q);

  always_comb begin
    pol_d    = pol_q;
    cnt_d    = cnt_eff;
    primed_d = 1'b1;
    edge_ok  = 1'b0;
    if (stb) begin
      if (!changed) begin
        cnt_d = reload;
      end else if (cnt_eff != '0) begin
        cnt_d = cnt_eff - DW'(1);
      end else begin
        cnt_d   = reload;
        pol_d   = await_pol_e'(~pol_q);
        edge_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q    <= AWAIT_RISE;
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (stb) begin
      pol_q    <= pol_d;
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
    end
  end

  assign await_pol = pol_q;
endmodule

// File: rtl/ewc_tally.sv
module ewc_tally #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          edge_ok,
  input  logic [CW-1:0] threshold,
  output logic          wake,
  output logic [CW-1:0] edges,
  output logic [CW-1:0] wakes
);
  logic [CW-1:0] edges_q, edges_d;
  logic [CW-1:0] wakes_q, wakes_d;
  logic          wake_q, wake_d;
  logic [CW-1:0] edges_inc;
  logic          upd_en;

  assign upd_en    = stb & edge_ok;
  assign edges_inc = edges_q + CW'(1);

  always_comb begin
    edges_d = edges_q;
    wakes_d = wakes_q;
    wake_d  = 1'b0;
    if (upd_en) begin
      if (edges_inc == threshold) begin
        edges_d = '0;
        wakes_d = wakes_q + CW'(1);
        wake_d  = 1'b1;
      end else begin
        edges_d = edges_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= '0;
      wakes_q <= '0;
    end else if (upd_en) begin
      edges_q <= edges_d;
      wakes_q <= wakes_d;
    end
  end

  // Wake flop runs every clock so the pulse is exactly one cycle wide.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake  = wake_q;
  assign edges = edges_q;
  assign wakes = wakes_q;
endmodule

// File: rtl/edge_wake_counter.sv
module edge_wake_counter #(
  parameter int unsigned DW          = 8,
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_stb,
  input  logic          raw_in,
  input  logic [DW-1:0] cfg_reload,
  input  logic [CW-1:0] cfg_threshold,
  output logic          wake_pulse,
  output logic [CW-1:0] edge_count,
  output logic [CW-1:0] wake_count
);
  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < ewc_pkg::MIN_SYNC_STAGES) ? ewc_pkg::MIN_SYNC_STAGES : SYNC_STAGES;

  logic rst_sync_n;
  logic lvl_sync;
  logic edge_ok;
  logic await_pol;

  ewc_rst_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  ewc_sync #(.STAGES(STAGES_EFF)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (raw_in),
    .q_out (lvl_sync)
  );

  ewc_debounce #(.DW(DW)) u_deb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stb       (sample_stb),
    .level     (lvl_sync),
    .reload    (cfg_reload),
    .edge_ok   (edge_ok),
    .await_pol (await_pol)
  );

  ewc_tally #(.CW(CW)) u_tally (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stb       (sample_stb),
    .edge_ok   (edge_ok),
    .threshold (cfg_threshold),
    .wake      (wake_pulse),
    .edges     (edge_count),
    .wakes     (wake_count)
  );
endmodule

// File: rtl/ewc_checker.sv
module ewc_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stb,
  input logic          lvl,
  input logic          edge_ok,
  input logic          await_pol,
  input logic          wake,
  input logic [CW-1:0] edges,
  input logic [CW-1:0] wakes
);
  // R5: the wake request lasts one clock only
  a_r5_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R5: a wake always leaves the edge count at zero
  a_r5_wake_clears_edges: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (edges == '0));

  // R5: a wake advances the wake counter by one
  a_r5_wake_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && edge_ok) |=> (wake ? (wakes == $past(wakes) + CW'(1)) : $stable(wakes)));

  // R7: nothing moves without the strobe
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(edges) && $stable(wakes) && $stable(await_pol)));

  // R2: a sample at the wrong level never confirms an edge
  a_r2_no_edge_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && (lvl != await_pol)) |-> !edge_ok);

  // R4: a confirmed edge flips the awaited polarity
  a_r4_pol_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ok |=> (await_pol != $past(await_pol)));

  // R3: without a confirmed edge the polarity holds
  a_r3_pol_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_ok |=> $stable(await_pol));

  // R4: a confirmed edge advances the edge count or ends in a wake
  a_r4_edge_advances: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ok |=> ((edges == $past(edges) + CW'(1)) || wake));
endmodule

bind edge_wake_counter ewc_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .stb       (sample_stb),
  .lvl       (lvl_sync),
  .edge_ok   (edge_ok),
  .await_pol (await_pol),
  .wake      (wake_pulse),
  .edges     (edge_count),
  .wakes     (wake_count)
);

// File: tb/edge_wake_counter_tb_top.sv
module edge_wake_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_stb;
  logic        raw_in;
  logic [7:0]  cfg_reload;
  logic [15:0] cfg_threshold;
  logic        wake_pulse;
  logic [15:0] edge_count;
  logic [15:0] wake_count;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  int m_pol, m_dbc, m_ec, m_wc, m_wake;

  always #10 clk = ~clk; // 50 MHz

  edge_wake_counter dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_stb    (sample_stb),
    .raw_in        (raw_in),
    .cfg_reload    (cfg_reload),
    .cfg_threshold (cfg_threshold),
    .wake_pulse    (wake_pulse),
    .edge_count    (edge_count),
    .wake_count    (wake_count)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int rl, input int th);
    @(negedge clk);
    rst_n = 1'b0; sample_stb = 1'b0; raw_in = 1'b0;
    cfg_reload = 8'(rl); cfg_threshold = 16'(th);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_pol = 1; m_dbc = rl; m_ec = 0; m_wc = 0; m_wake = 0;
  endtask

  // One sample: level set three clocks ahead of the strobe edge (R8 latency).
  task automatic sample(input int lvl);
    string tag;
    @(negedge clk);
    raw_in = lvl[0];
    @(negedge clk);
    @(negedge clk);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    m_wake = 0;
    if (lvl != m_pol) begin
      tag = "R2 unchanged sample";
      m_dbc = int'(cfg_reload);
    end else if (m_dbc != 0) begin
      tag = "R3 debounce decrement";
      m_dbc--;
    end else begin
      tag = "R4 edge confirm";
      m_dbc = int'(cfg_reload);
      m_pol = 1 - m_pol;
      m_ec = (m_ec + 1) % 65536;
      if (m_ec == int'(cfg_threshold)) begin
        tag = "R5 wake";
        m_ec = 0; m_wc = (m_wc + 1) % 65536; m_wake = 1;
      end
    end
    check({tag, " edge_count"}, int'(edge_count), m_ec);
    check({tag, " wake_count"}, int'(wake_count), m_wc);
    check({tag, " wake_pulse"}, int'(wake_pulse), m_wake);
    if (m_wake == 1) begin
      @(negedge clk);
      check("R5 wake pulse ends", int'(wake_pulse), 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin : stim
    int ec_before;
    // R1: reset state and first awaited edge is rising
    do_reset(3, 2);
    check("R1 edge_count", int'(edge_count), 0);
    check("R1 wake_count", int'(wake_count), 0);
    check("R1 wake_pulse", int'(wake_pulse), 0);
    sample(0);
    sample(1); sample(1); sample(1);
    check("R6 reload samples do not confirm", int'(edge_count), 0);
    sample(1);
    check("R6 reload+1 samples confirm", int'(edge_count), 1);
    repeat (4) sample(0);
    check("R5 one pulse gives one wake", int'(wake_count), 1);

    // R7: raw activity with no strobe changes nothing
    ec_before = int'(edge_count);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      raw_in = k[1];
      check("R7 edge_count without strobe", int'(edge_count), ec_before);
      check("R7 wake_pulse without strobe", int'(wake_pulse), 0);
    end
    sample(1); sample(1); sample(1); sample(1);

    // Sweep small configurations with alternating runs of varied length
    for (int rl = 0; rl <= 3; rl++) begin
      for (int th = 1; th <= 3; th++) begin
        do_reset(rl, th);
        for (int len = 1; len <= 5; len++) begin
          repeat (len) sample(1);
          repeat (len) sample(0);
        end
      end
    end

    // R8: a change one clock before the strobe edge is not seen
    do_reset(0, 5);
    @(negedge clk);
    raw_in = 1'b1; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    check("R8 late change not sampled", int'(edge_count), 0);
    @(negedge clk);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    check("R8 change after two flops sampled", int'(edge_count), 1);

    // R9: threshold 0 wakes on the wrap of edge_count
    do_reset(0, 0);
    for (int k = 1; k <= 65538; k++) begin
      raw_in = k[0];
      sample_stb = 1'b1;
      @(negedge clk);
      if (k == 65537) begin
        check("R9 edge_count before wrap", int'(edge_count), 65535);
        check("R9 no wake before wrap", int'(wake_count), 0);
      end
    end
    sample_stb = 1'b0;
    check("R9 edge_count wrapped", int'(edge_count), 0);
    check("R9 wake at wrap", int'(wake_count), 1);
    check("R9 wake pulse at wrap", int'(wake_pulse), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule